// File: doc/BRIEF.md
# Interrupt Context Sequencer

This block sits beside a small 8-bit processor core and takes over the core's memory port while it saves or restores the machine context for an interrupt. It owns two of the core's eight registers: register 5 holds the interrupt enable mask and register 6 holds the interrupt status. A free-running timer sets status bit 0 once per configured period. Whenever the core reaches an instruction boundary with an enabled status bit set, the block takes the interrupt before the instruction is decoded. It clears the status and pushes the return PC, the flags and registers 0 to 6 onto the memory stack. It then reads the handler address from a table of eight bytes at the top of memory and hands it to the core as the new PC.

When the core decodes a return-from-interrupt instruction, it pulses a request. The block then pops the saved context in the exact reverse order, writes each value back to its owner, and returns the stack pointer and the PC to the core. While either sequence runs, a busy output keeps the core stalled. The core's own writes to the mask and status registers are discarded during that time. A timer tick that lands during a sequence is kept and merged into the status once the sequence ends.

The memory port is a valid/ready request channel. The block raises `mem_valid_o` for every beat. A beat completes in a cycle where `mem_valid_o` and `mem_ready_i` are both high. While `mem_ready_i` is low, the address, write flag and write data are held unchanged. Read data on `mem_rdata_i` must belong to the presented address in the completing cycle.

Top module: `intr_ctx_seq`

## Requirements
- R1: An interrupt is pending when (mask AND status) is nonzero. The lowest-numbered set bit of that AND selects the interrupt number i.
- R2: `irq_take_o` is high in the same cycle as `boundary_i` whenever an interrupt is pending and the block is idle. This holds whatever instruction the core is about to run, and a take overrides a simultaneous `iret_req_i`. With nothing pending, `irq_take_o` stays low and no sequence starts.
- R3: A take clears status to 0 at the next clock edge. Status reads 0 (bit 0 apart from ticks held by R9) when the sequence ends.
- R4: With the stack pointer S from `sp_i` at the take, the entry sequence writes the PC to address S and the flags to S-1. It then writes registers 0 to 6 to S-2 down to S-8, where register 5 is the mask and register 6 is the already-cleared status (0). Register 7 is not saved. The final stack pointer written back is S-9.
- R5: The last entry beat reads address 0xF8+i. In that beat's completing cycle, `pc_wr_o` and `sp_wr_o` pulse, with `pc_wdata_o` equal to the byte read.
- R6: On a return with stack pointer S, the block reads S+1 to S+9. It writes register 6, then 5, down to register 0, then the flags, then the PC. Registers 0 to 4 go out on the register write port, registers 5 and 6 back into the block, and the stack pointer written back is S+9.
- R7: Each push or pop is one valid/ready beat. A stalled request keeps its address and data stable. With `mem_ready_i` held high, busy lasts exactly 10 cycles for entry and 9 cycles for return.
- R8: The timer ORs a 1 into status bit 0 once every TICK_PERIOD clock cycles, leaving the other bits unchanged.
- R9: A tick that falls while busy (or in the take cycle) is held. It is ORed into status bit 0 on the clock edge that follows the first idle cycle.
- R10: Configuration writes to register 5 (mask) or 6 (status) made while busy have no effect.
- R11: After reset, busy, mask, status and `mem_valid_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boundary_i | input | 1 | Core is at an instruction boundary, before decode |
| iret_req_i | input | 1 | Core decoded a return-from-interrupt |
| irq_take_o | output | 1 | Interrupt taken this cycle; core must not decode |
| busy_o | output | 1 | Sequence in progress; core stalls |
| pc_i | input | 8 | Address of the next, unexecuted instruction |
| flags_i | input | 8 | Core flags |
| sp_i | input | 8 | Core stack pointer (register 7) |
| pc_wr_o | output | 1 | Load new PC |
| pc_wdata_o | output | 8 | New PC |
| fl_wr_o | output | 1 | Load restored flags |
| fl_wdata_o | output | 8 | Restored flags |
| sp_wr_o | output | 1 | Load new stack pointer |
| sp_wdata_o | output | 8 | New stack pointer |
| cfg_we_i | input | 1 | Core register write strobe |
| cfg_addr_i | input | 3 | Register index; only 5 and 6 act here |
| cfg_wdata_i | input | 8 | Register write data |
| mask_o | output | 8 | Register 5 (enable mask) |
| status_o | output | 8 | Register 6 (interrupt status) |
| rf_raddr_o | output | 3 | Core register file read index |
| rf_rdata_i | input | 8 | Core register file read data |
| rf_we_o | output | 1 | Core register file write strobe |
| rf_waddr_o | output | 3 | Core register file write index |
| rf_wdata_o | output | 8 | Core register file write data |
| mem_valid_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory request accepted |
| mem_write_o | output | 1 | Request is a write |
| mem_addr_o | output | 8 | Request address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data for the presented address |

## Verification
`irq_take_o` is combinational, so the bench checks it one time unit after raising `boundary_i`. Busy is first seen high at the next falling edge and is counted falling edge by falling edge until it drops. That count is 10 for entry and 9 for return when ready stays high. All write strobes (memory, PC, flags, stack pointer, registers) act on the completing beat's rising edge. The bench captures them there and compares them only after busy has fallen. A tick held during a sequence shows in status one falling edge after busy is first seen low, so the bench reads status at both of those edges. The timer period is measured as the number of falling edges between a status clear and the next bit-0 rise.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_SAVE = 2'd1,
    SQ_LOAD = 2'd2
  } sq_state_e;
endpackage

// File: rtl/intr_lsb_pick.sv
module intr_lsb_pick #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  logic [N-1:0] below;
  logic [N-1:0] grant;

  assign below[0] = 1'b0;
  for (genvar g = 1; g < N; g++) begin : g_below
    assign below[g] = |req_i[g-1:0];
  end

  assign grant = req_i & ~below;
  assign any_o = |req_i;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx_o = idx_o | IW'(i);
    end
  end
endmodule

// File: rtl/intr_irq_regs.sv
module intr_irq_regs #(
  parameter int DW          = 8,
  parameter int TICK_PERIOD = 1000,
  parameter int MASK_ADDR   = 5,
  parameter int STAT_ADDR   = 6,
  localparam int TW = (TICK_PERIOD > 1) ? $clog2(TICK_PERIOD) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy_i,
  input  logic          take_i,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_addr_i,
  input  logic [DW-1:0] cfg_wdata_i,
  input  logic          rst_wr_i,
  input  logic          rst_is_mask_i,
  input  logic [DW-1:0] rst_data_i,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] status_o
);
  logic [TW-1:0] cnt_q;
  logic          tick_now;
  logic          tick_pend_q;
  logic          apply_ok;
  logic [DW-1:0] tick_bits;

  assign tick_now  = (cnt_q == TW'(TICK_PERIOD - 1));
  assign apply_ok  = !busy_i && !take_i;
  assign tick_bits = {{(DW-1){1'b0}}, (tick_pend_q | tick_now)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      tick_pend_q <= 1'b0;
    end else begin
      cnt_q       <= tick_now ? '0 : cnt_q + TW'(1);
      tick_pend_q <= (tick_pend_q | tick_now) & !apply_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_o <= '0;
    end else if (take_i) begin
      status_o <= '0;
    end else if (rst_wr_i && !rst_is_mask_i) begin
      status_o <= rst_data_i;
    end else if (apply_ok) begin
      if (cfg_we_i && cfg_addr_i == 3'(STAT_ADDR)) status_o <= cfg_wdata_i | tick_bits;
      else                                          status_o <= status_o | tick_bits;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o <= '0;
    end else if (rst_wr_i && rst_is_mask_i) begin
      mask_o <= rst_data_i;
    end else if (!busy_i && cfg_we_i && cfg_addr_i == 3'(MASK_ADDR)) begin
      mask_o <= cfg_wdata_i;
    end
  end

  // R3: a take leaves the status empty on the next edge
  assert_clear_on_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> status_o == '0);

  // R9: a tick arriving while busy is kept for later
  assert_hold_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && tick_now) |=> tick_pend_q);

  // R10: outside a restore beat, the mask cannot move while busy
  assert_mask_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !rst_wr_i) |=> $stable(mask_o));
endmodule

// File: rtl/intr_ctx_fsm.sv
module intr_ctx_fsm
  import intr_seq_pkg::*;
#(
  parameter int          DW       = 8,
  parameter int          AW       = 8,
  parameter int          NREG     = 8,
  parameter logic [7:0]  VEC_BASE = 8'hF8,
  localparam int IW          = $clog2(DW),
  localparam int RIW         = $clog2(NREG),
  localparam int NSAVE       = NREG - 1,
  localparam int SAVE_BEATS  = NSAVE + 3,
  localparam int LOAD_BEATS  = NSAVE + 2,
  localparam int BW          = $clog2(SAVE_BEATS),
  localparam int MASK_R      = NREG - 3,
  localparam int STAT_R      = NREG - 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take_i,
  input  logic [IW-1:0]  irq_idx_i,
  input  logic           iret_go_i,
  input  logic [AW-1:0]  pc_i,
  input  logic [DW-1:0]  flags_i,
  input  logic [AW-1:0]  sp_i,
  input  logic [DW-1:0]  mask_i,
  input  logic [DW-1:0]  status_i,
  input  logic [DW-1:0]  rf_rdata_i,
  input  logic           mem_ready_i,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic           busy_o,
  output logic [RIW-1:0] rf_raddr_o,
  output logic           mem_valid_o,
  output logic           mem_write_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  output logic           pc_wr_o,
  output logic [AW-1:0]  pc_wdata_o,
  output logic           fl_wr_o,
  output logic [DW-1:0]  fl_wdata_o,
  output logic           sp_wr_o,
  output logic [AW-1:0]  sp_wdata_o,
  output logic           rf_we_o,
  output logic [RIW-1:0] rf_waddr_o,
  output logic [DW-1:0]  rf_wdata_o,
  output logic           rst_wr_o,
  output logic           rst_is_mask_o,
  output logic [DW-1:0]  rst_data_o
);
  sq_state_e      state_q;
  logic [BW-1:0]  beat_q;
  logic [AW-1:0]  sp_q;
  logic [IW-1:0]  idx_q;
  logic [AW-1:0]  pc_q;
  logic [DW-1:0]  fl_q;

  logic           hs;
  logic           in_save;
  logic           in_load;
  logic           save_last;
  logic           load_last;
  logic [RIW-1:0] sv_reg;
  logic [RIW-1:0] ld_reg;
  logic [DW-1:0]  sv_val;
  logic           ld_is_reg;
  logic           ld_is_own;

  assign in_save   = (state_q == SQ_SAVE);
  assign in_load   = (state_q == SQ_LOAD);
  assign busy_o    = (state_q != SQ_IDLE);
  assign save_last = (beat_q == BW'(SAVE_BEATS - 1));
  assign load_last = (beat_q == BW'(LOAD_BEATS - 1));
  assign sv_reg    = RIW'(beat_q - BW'(2));
  assign ld_reg    = RIW'(BW'(NSAVE - 1) - beat_q);

  assign mem_valid_o = busy_o;
  assign hs          = mem_valid_o && mem_ready_i;
  assign rf_raddr_o  = sv_reg;

  always_comb begin
    if (sv_reg == RIW'(MASK_R))      sv_val = mask_i;
    else if (sv_reg == RIW'(STAT_R)) sv_val = status_i;
    else                             sv_val = rf_rdata_i;
  end

  always_comb begin
    mem_write_o = in_save && !save_last;
    mem_wdata_o = '0;
    mem_addr_o  = sp_q;
    if (in_save) begin
      if (save_last) mem_addr_o = AW'(VEC_BASE) + AW'(idx_q);
      if (beat_q == BW'(0))      mem_wdata_o = DW'(pc_q);
      else if (beat_q == BW'(1)) mem_wdata_o = fl_q;
      else                       mem_wdata_o = sv_val;
    end else if (in_load) begin
      mem_addr_o = sp_q + AW'(1);
    end
  end

  assign ld_is_reg     = in_load && hs && (beat_q < BW'(NSAVE));
  assign ld_is_own     = (ld_reg == RIW'(MASK_R)) || (ld_reg == RIW'(STAT_R));
  assign rf_we_o       = ld_is_reg && !ld_is_own;
  assign rf_waddr_o    = ld_reg;
  assign rf_wdata_o    = mem_rdata_i;
  assign rst_wr_o      = ld_is_reg && ld_is_own;
  assign rst_is_mask_o = (ld_reg == RIW'(MASK_R));
  assign rst_data_o    = mem_rdata_i;
  assign fl_wr_o       = in_load && hs && (beat_q == BW'(NSAVE));
  assign fl_wdata_o    = mem_rdata_i;
  assign pc_wr_o       = hs && ((in_save && save_last) || (in_load && load_last));
  assign pc_wdata_o    = AW'(mem_rdata_i);
  assign sp_wr_o       = pc_wr_o;
  assign sp_wdata_o    = in_save ? sp_q : sp_q + AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      beat_q  <= '0;
      sp_q    <= '0;
      idx_q   <= '0;
      pc_q    <= '0;
      fl_q    <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          beat_q <= '0;
          if (take_i) begin
            state_q <= SQ_SAVE;
            sp_q    <= sp_i;
            idx_q   <= irq_idx_i;
            pc_q    <= pc_i;
            fl_q    <= flags_i;
          end else if (iret_go_i) begin
            state_q <= SQ_LOAD;
            sp_q    <= sp_i;
          end
        end
        SQ_SAVE: if (hs) begin
          if (save_last) state_q <= SQ_IDLE;
          else begin
            beat_q <= beat_q + BW'(1);
            sp_q   <= sp_q - AW'(1);
          end
        end
        SQ_LOAD: if (hs) begin
          sp_q <= sp_q + AW'(1);
          if (load_last) state_q <= SQ_IDLE;
          else           beat_q  <= beat_q + BW'(1);
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  // R7: a refused request holds its address, data and direction
  assert_req_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && !mem_ready_i) |=>
      (mem_valid_o && $stable(mem_addr_o) && $stable(mem_wdata_o) && $stable(mem_write_o)));

  // R4: the first push stores the interrupted PC at the incoming stack pointer
  assert_first_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (mem_write_o && mem_addr_o == $past(sp_i) && mem_wdata_o == DW'($past(pc_i))));

  // R4: each push goes one address below the previous one
  assert_push_descend_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_save && hs && beat_q < BW'(NSAVE + 1)) |=> mem_addr_o == $past(mem_addr_o) - AW'(1));

  // R6: each pop goes one address above the previous one
  assert_pop_ascend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_load && hs && !load_last) |=> mem_addr_o == $past(mem_addr_o) + AW'(1));
endmodule

// File: rtl/intr_ctx_seq.sv
module intr_ctx_seq #(
  parameter int         DW          = 8,
  parameter int         AW          = 8,
  parameter int         NREG        = 8,
  parameter int         TICK_PERIOD = 1000,
  parameter logic [7:0] VEC_BASE    = 8'hF8,
  localparam int IW  = $clog2(DW),
  localparam int RIW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           boundary_i,
  input  logic           iret_req_i,
  output logic           irq_take_o,
  output logic           busy_o,
  input  logic [AW-1:0]  pc_i,
  input  logic [DW-1:0]  flags_i,
  input  logic [AW-1:0]  sp_i,
  output logic           pc_wr_o,
  output logic [AW-1:0]  pc_wdata_o,
  output logic           fl_wr_o,
  output logic [DW-1:0]  fl_wdata_o,
  output logic           sp_wr_o,
  output logic [AW-1:0]  sp_wdata_o,
  input  logic           cfg_we_i,
  input  logic [2:0]     cfg_addr_i,
  input  logic [DW-1:0]  cfg_wdata_i,
  output logic [DW-1:0]  mask_o,
  output logic [DW-1:0]  status_o,
  output logic [RIW-1:0] rf_raddr_o,
  input  logic [DW-1:0]  rf_rdata_i,
  output logic           rf_we_o,
  output logic [RIW-1:0] rf_waddr_o,
  output logic [DW-1:0]  rf_wdata_o,
  output logic           mem_valid_o,
  input  logic           mem_ready_i,
  output logic           mem_write_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic [DW-1:0]  mem_rdata_i
);
  logic [DW-1:0] enabled;
  logic          pending;
  logic [IW-1:0] irq_idx;
  logic          iret_go;
  logic          rst_wr;
  logic          rst_is_mask;
  logic [DW-1:0] rst_data;

  assign enabled    = mask_o & status_o;
  assign irq_take_o = boundary_i && pending && !busy_o;
  assign iret_go    = iret_req_i && !busy_o && !irq_take_o;

  intr_lsb_pick #(.N(DW)) u_pick (
    .req_i (enabled),
    .any_o (pending),
    .idx_o (irq_idx)
  );

  intr_irq_regs #(
    .DW(DW), .TICK_PERIOD(TICK_PERIOD), .MASK_ADDR(NREG - 3), .STAT_ADDR(NREG - 2)
  ) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy_i        (busy_o),
    .take_i        (irq_take_o),
    .cfg_we_i      (cfg_we_i),
    .cfg_addr_i    (cfg_addr_i),
    .cfg_wdata_i   (cfg_wdata_i),
    .rst_wr_i      (rst_wr),
    .rst_is_mask_i (rst_is_mask),
    .rst_data_i    (rst_data),
    .mask_o        (mask_o),
    .status_o      (status_o)
  );

  intr_ctx_fsm #(
    .DW(DW), .AW(AW), .NREG(NREG), .VEC_BASE(VEC_BASE)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .take_i        (irq_take_o),
    .irq_idx_i     (irq_idx),
    .iret_go_i     (iret_go),
    .pc_i          (pc_i),
    .flags_i       (flags_i),
    .sp_i          (sp_i),
    .mask_i        (mask_o),
    .status_i      (status_o),
    .rf_rdata_i    (rf_rdata_i),
    .mem_ready_i   (mem_ready_i),
    .mem_rdata_i   (mem_rdata_i),
    .busy_o        (busy_o),
    .rf_raddr_o    (rf_raddr_o),
    .mem_valid_o   (mem_valid_o),
    .mem_write_o   (mem_write_o),
    .mem_addr_o    (mem_addr_o),
    .mem_wdata_o   (mem_wdata_o),
    .pc_wr_o       (pc_wr_o),
    .pc_wdata_o    (pc_wdata_o),
    .fl_wr_o       (fl_wr_o),
    .fl_wdata_o    (fl_wdata_o),
    .sp_wr_o       (sp_wr_o),
    .sp_wdata_o    (sp_wdata_o),
    .rf_we_o       (rf_we_o),
    .rf_waddr_o    (rf_waddr_o),
    .rf_wdata_o    (rf_wdata_o),
    .rst_wr_o      (rst_wr),
    .rst_is_mask_o (rst_is_mask),
    .rst_data_o    (rst_data)
  );

  // R1: the chosen number is an enabled bit with no enabled bit below it
  assert_lowest_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> (enabled[irq_idx] && ((enabled & ((DW'(1) << irq_idx) - DW'(1))) == '0)));

  // R2: a take starts a sequence on the next cycle
  assert_take_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take_o |=> busy_o);

  // R2: no take without an enabled status bit
  assert_no_spurious_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled == '0) |-> !irq_take_o);
endmodule

// File: tb/intr_ctx_seq_tb.sv
module intr_ctx_seq_tb;
  localparam int PER = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       boundary, iret_req, irq_take, busy;
  logic [7:0] pc_in, flags_in, sp_in;
  logic       pc_wr, fl_wr, sp_wr;
  logic [7:0] pc_wdata, fl_wdata, sp_wdata;
  logic       cfg_we;
  logic [2:0] cfg_addr;
  logic [7:0] cfg_wdata, mask, status;
  logic [2:0] rf_raddr, rf_waddr;
  logic [7:0] rf_rdata, rf_wdata;
  logic       rf_we;
  logic       mem_valid, mem_ready, mem_write;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;

  logic [7:0] mem [256];
  logic [7:0] rf [8];
  logic [7:0] got_pc, got_fl, got_sp;
  int         pc_cnt;
  int         ready_mode;
  int         checks = 0;
  int         errors = 0;

  assign mem_rdata = mem[mem_addr];
  assign rf_rdata  = rf[rf_raddr];

  intr_ctx_seq #(.TICK_PERIOD(PER)) u_dut (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary), .iret_req_i(iret_req),
    .irq_take_o(irq_take), .busy_o(busy), .pc_i(pc_in), .flags_i(flags_in), .sp_i(sp_in),
    .pc_wr_o(pc_wr), .pc_wdata_o(pc_wdata), .fl_wr_o(fl_wr), .fl_wdata_o(fl_wdata),
    .sp_wr_o(sp_wr), .sp_wdata_o(sp_wdata), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .mask_o(mask), .status_o(status), .rf_raddr_o(rf_raddr),
    .rf_rdata_i(rf_rdata), .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready), .mem_write_o(mem_write),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_valid && mem_ready && mem_write) mem[mem_addr] <= mem_wdata;
    if (rf_we) rf[rf_waddr] <= rf_wdata;
    if (pc_wr) begin got_pc <= pc_wdata; pc_cnt <= pc_cnt + 1; end
    if (fl_wr) got_fl <= fl_wdata;
    if (sp_wr) got_sp <= sp_wdata;
  end

  always @(negedge clk) begin
    if (ready_mode == 0)      mem_ready <= 1'b1;
    else if (ready_mode == 1) mem_ready <= ~mem_ready;
    else                      mem_ready <= 1'b0;
  end

  // rows: mask, status, expected interrupt number, stall the memory
  localparam logic [19:0] VECS [5] = '{
    {8'h0E, 8'h0C, 3'd2, 1'b0},
    {8'hFE, 8'h80, 3'd7, 1'b0},
    {8'h03, 8'h03, 3'd0, 1'b1},
    {8'hF0, 8'h50, 3'd4, 1'b1},
    {8'h22, 8'hFF, 3'd1, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run_entry(input int row, input logic [7:0] m, input logic [7:0] s,
                           input int idx, input logic stall);
    int n;
    int p0;
    pc_in = 8'h40 + 8'(row); flags_in = 8'hA0 + 8'(row); sp_in = 8'hF3;
    for (int k = 0; k < 5; k++) rf[k] = 8'h50 + 8'(16 * row + k);
    cfg_write(3'd5, m);
    cfg_write(3'd6, s);
    p0 = pc_cnt;
    @(negedge clk);
    ready_mode = stall ? 1 : 0;
    boundary = 1'b1;
    #1;
    chk("R2 take at boundary", 32'(irq_take), 32'd1);
    @(negedge clk);
    boundary = 1'b0;
    wait_idle(n);
    ready_mode = 0;
    if (!stall) chk("R7 entry busy cycles", 32'(n), 32'd10);
    else        chk("R7 stalled entry longer", 32'(n > 10), 32'd1);
    chk("R5 one pc load", 32'(pc_cnt - p0), 32'd1);
    chk("R1 R5 vector pc", 32'(got_pc), 32'((idx + 1) * 16));
    chk("R4 final sp", 32'(got_sp), 32'hEA);
    chk("R3 status cleared", 32'(status & 8'hFE), 32'd0);
    chk("R4 pc slot", 32'(mem[8'hF3]), 32'(pc_in));
    chk("R4 flags slot", 32'(mem[8'hF2]), 32'(flags_in));
    for (int k = 0; k < 5; k++)
      chk("R4 reg slot", 32'(mem[8'hF1 - 8'(k)]), 32'(8'h50 + 8'(16 * row + k)));
    chk("R4 mask slot", 32'(mem[8'hEC]), 32'(m));
    chk("R4 status slot", 32'(mem[8'hEB]), 32'd0);
  endtask

  task automatic run_iret(input int row, input logic [7:0] m, input logic stall);
    int n;
    for (int k = 0; k < 5; k++) rf[k] = 8'h00;
    cfg_write(3'd5, 8'h00);
    sp_in = 8'hEA; pc_in = 8'h00; flags_in = 8'h00;
    @(negedge clk);
    ready_mode = stall ? 1 : 0;
    iret_req = 1'b1;
    @(negedge clk);
    iret_req = 1'b0;
    wait_idle(n);
    ready_mode = 0;
    if (!stall) chk("R7 return busy cycles", 32'(n), 32'd9);
    for (int k = 0; k < 5; k++)
      chk("R6 reg restored", 32'(rf[k]), 32'(8'h50 + 8'(16 * row + k)));
    chk("R6 mask restored", 32'(mask), 32'(m));
    chk("R6 status restored", 32'(status & 8'hFE), 32'd0);
    chk("R6 flags restored", 32'(got_fl), 32'(8'hA0 + 8'(row)));
    chk("R6 pc restored", 32'(got_pc), 32'(8'h40 + 8'(row)));
    chk("R6 sp restored", 32'(got_sp), 32'hF3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    boundary = 0; iret_req = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    pc_in = 0; flags_in = 0; sp_in = 8'hF3; ready_mode = 0; mem_ready = 1'b1;
    pc_cnt = 0; got_pc = 0; got_fl = 0; got_sp = 0;
    for (int a = 0; a < 256; a++) mem[a] = 8'h00;
    for (int i = 0; i < 8; i++) mem[8'hF8 + 8'(i)] = 8'((i + 1) * 16);
    for (int k = 0; k < 8; k++) rf[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 busy after reset", 32'(busy), 32'd0);
    chk("R11 mask after reset", 32'(mask), 32'd0);
    chk("R11 status after reset", 32'(status), 32'd0);
    chk("R11 valid after reset", 32'(mem_valid), 32'd0);

    for (int r = 0; r < 5; r++) begin
      run_entry(r, VECS[r][19:12], VECS[r][11:4], int'(VECS[r][3:1]), VECS[r][0]);
      run_iret(r, VECS[r][19:12], VECS[r][0]);
    end

    // R2: nothing enabled, no take
    cfg_write(3'd5, 8'h04);
    cfg_write(3'd6, 8'h02);
    @(negedge clk);
    boundary = 1'b1;
    #1;
    chk("R2 no take when nothing pending", 32'(irq_take), 32'd0);
    @(negedge clk);
    boundary = 1'b0;
    chk("R2 stays idle", 32'(busy), 32'd0);

    // R2: a take overrides a simultaneous return request
    cfg_write(3'd6, 8'h04);
    sp_in = 8'hF3; pc_in = 8'h33;
    @(negedge clk);
    boundary = 1'b1; iret_req = 1'b1;
    @(negedge clk);
    boundary = 1'b0; iret_req = 1'b0;
    chk("R2 take wins over return", 32'(mem_write), 32'd1);
    wait_idle(n);
    chk("R2 entry length on collision", 32'(n), 32'd10);
    chk("R2 vector on collision", 32'(got_pc), 32'h30);

    // R8: period between status clear and the next tick
    cfg_write(3'd5, 8'h00);
    cfg_write(3'd6, 8'h00);
    n = 0;
    while (!status[0] && n < 500) begin @(negedge clk); n++; end
    cfg_write(3'd6, 8'h00);
    n = 2;
    while (!status[0] && n < 500) begin @(negedge clk); n++; end
    chk("R8 tick period", 32'(n), 32'(PER));
    chk("R8 only bit 0 set", 32'(status), 32'd1);

    // R9 and R10: tick held across a stalled entry, config writes ignored
    cfg_write(3'd5, 8'h02);
    cfg_write(3'd6, 8'h02);
    sp_in = 8'hF3;
    @(negedge clk);
    ready_mode = 2;
    boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
    cfg_write(3'd5, 8'hFF);
    cfg_write(3'd6, 8'h80);
    repeat (PER + 8) @(negedge clk);
    chk("R7 stalled request still waiting", 32'(mem_valid && busy), 32'd1);
    ready_mode = 0;
    wait_idle(n);
    chk("R9 tick not yet applied at idle", 32'(status), 32'd0);
    @(negedge clk);
    chk("R9 held tick applied", 32'(status), 32'd1);
    chk("R10 mask write ignored while busy", 32'(mask), 32'h02);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule